// File: doc/BRIEF.md
# Single-Precision Float Classifier and Comparator

This block takes two 32-bit binary floating-point words and gives back their ordering relation and a class code for each word. Bit 31 is the sign, bits 30:23 hold an 8-bit exponent biased by 127, and bits 22:0 hold the fraction. The ordering comes from comparing the raw words as sign-and-magnitude integers. The two zeros and the NaN encodings are then corrected on top of that integer comparison. The exponent and fraction are never unpacked for arithmetic.

The outputs are four relation flags (less, equal, greater, unordered), an invalid flag and two 4-bit class codes. A parameter chooses between a purely combinational path and a single output register stage. The register stage is the default.

Top module: `fp32_cmp_class`

## Requirements
- R1: Class code = {kind[2:0], sign}, where kind is 0 for zero (exponent 0, fraction 0), 1 for subnormal (exponent 0, fraction nonzero), 2 for normal (exponent 1..254) and 3 for infinity (exponent 255, fraction 0). Bit 0 is the operand's bit 31.
- R2: An exponent of 255 with fraction bit 22 set gives class code 8 (quiet NaN). An exponent of 255 with bit 22 clear and a nonzero fraction gives class code 10 (signaling NaN). The sign is not reported for a NaN.
- R3: Exactly one of is_lt, is_eq, is_gt and is_unord is high.
- R4: If either operand is a NaN, is_unord is high and is_lt, is_eq and is_gt are all low.
- R5: Positive zero and negative zero compare equal to each other in either order.
- R6: For two non-NaN operands that are both non-negative, the order follows numeric value. This includes subnormals and +infinity.
- R7: For two negative non-NaN operands, the operand with the larger magnitude is the lesser one.
- R8: When the signs differ and the operands are not the zero pair, the negative operand is less than the positive one.
- R9: invalid is high exactly when at least one operand is a signaling NaN. A quiet NaN alone leaves it low.
- R10: With REG_OUT=1, the outputs reflect the inputs one rising clock edge later, and an active-low rst_n forces every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| is_lt | output | 1 | op_a is less than op_b |
| is_eq | output | 1 | op_a equals op_b |
| is_gt | output | 1 | op_a is greater than op_b |
| is_unord | output | 1 | At least one operand is a NaN |
| invalid | output | 1 | At least one operand is a signaling NaN |
| class_a | output | 4 | Class code of op_a |
| class_b | output | 4 | Class code of op_b |

## Verification
The assertions check these relations on every cycle:
- exactly one relation flag is set;
- the unordered flag is set only when a class code marks a NaN;
- the invalid flag agrees with the signaling-NaN class codes;
- a pair of zeros compares equal;
- the registered outputs repeat the previous cycle's combinational result.

Some behaviour cannot be shown by those relations and is left to the bench's scenarios:
- the actual numeric ordering of values, including the reversal for two negatives and the cases across the sign;
- the exact class codes for each encoding;
- the clearing of the outputs by reset.

// File: rtl/fp32_cmp_class.sv
module fp32_cmp_class #(
  parameter int W       = 32,
  parameter int EXP_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         is_lt,
  output logic         is_eq,
  output logic         is_gt,
  output logic         is_unord,
  output logic         invalid,
  output logic [3:0]   class_a,
  output logic [3:0]   class_b
);
  localparam int FRAC_W = W - 1 - EXP_W;
  localparam int MAG_W  = W - 1;

  function automatic logic [3:0] classify(input logic [W-1:0] w);
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    e = w[W-2 -: EXP_W];
    f = w[FRAC_W-1:0];
    if (e == '1) begin
      if (f == '0)            classify = {3'd3, w[W-1]};
      else if (f[FRAC_W-1])   classify = 4'd8;
      else                    classify = 4'd10;
    end else if (e == '0) begin
      classify = (f == '0) ? {3'd0, w[W-1]} : {3'd1, w[W-1]};
    end else begin
      classify = {3'd2, w[W-1]};
    end
  endfunction

  function automatic logic nan_of(input logic [W-1:0] w);
    nan_of = (w[W-2 -: EXP_W] == '1) && (w[FRAC_W-1:0] != '0);
  endfunction

  function automatic logic snan_of(input logic [W-1:0] w);
    snan_of = nan_of(w) && !w[FRAC_W-1];
  endfunction

  logic [3:0] cls_a_c, cls_b_c;
  logic       lt_c, eq_c, gt_c, unord_c, inv_c;

  wire             sa    = op_a[W-1];
  wire             sb    = op_b[W-1];
  wire [MAG_W-1:0] mag_a = op_a[MAG_W-1:0];
  wire [MAG_W-1:0] mag_b = op_b[MAG_W-1:0];
  wire             zero2 = (mag_a == '0) && (mag_b == '0);
  wire             mless = mag_a < mag_b;

  assign cls_a_c = classify(op_a);
  assign cls_b_c = classify(op_b);
  assign unord_c = nan_of(op_a) || nan_of(op_b);
  assign inv_c   = snan_of(op_a) || snan_of(op_b);

  always_comb begin
    lt_c = 1'b0;
    eq_c = 1'b0;
    gt_c = 1'b0;
    if (unord_c) begin
      lt_c = 1'b0;
    end else if (zero2 || op_a == op_b) begin
      eq_c = 1'b1;
    end else if (sa != sb) begin
      lt_c = sa;
      gt_c = sb;
    end else begin
      lt_c = mless ^ sa;
      gt_c = ~(mless ^ sa);
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          {is_lt, is_eq, is_gt, is_unord, invalid} <= '0;
          class_a <= '0;
          class_b <= '0;
        end else begin
          {is_lt, is_eq, is_gt, is_unord, invalid} <= {lt_c, eq_c, gt_c, unord_c, inv_c};
          class_a <= cls_a_c;
          class_b <= cls_b_c;
        end
      end

      // R10
      reg_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({is_lt, is_eq, is_gt, is_unord, invalid, class_a, class_b} ==
                  $past({lt_c, eq_c, gt_c, unord_c, inv_c, cls_a_c, cls_b_c})));
    end else begin : g_comb
      assign {is_lt, is_eq, is_gt, is_unord, invalid} = {lt_c, eq_c, gt_c, unord_c, inv_c};
      assign class_a = cls_a_c;
      assign class_b = cls_b_c;
    end
  endgenerate

  // R3
  one_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lt_c, eq_c, gt_c, unord_c}) == 1);

  // R4
  unord_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unord_c |-> (cls_a_c[3] || cls_b_c[3]) && !lt_c && !eq_c && !gt_c);

  // R9
  invalid_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_c == ((cls_a_c == 4'd10) || (cls_b_c == 4'd10)));

  // R5
  zero_pair_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_a_c[3:1] == 3'd0 && cls_b_c[3:1] == 3'd0) |-> eq_c);
endmodule

// File: tb/fp32_cmp_class_bench.sv
module fp32_cmp_class_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // fields: op_a, op_b, {lt,eq,gt,unord,invalid}, class_a, class_b
  localparam logic [76:0] VEC [NV] = '{
    {32'h3f800000, 32'h40000000, 5'b10000, 4'd4,  4'd4},   // R6
    {32'h40000000, 32'h3f800000, 5'b00100, 4'd4,  4'd4},   // R6
    {32'h00000000, 32'h80000000, 5'b01000, 4'd0,  4'd1},   // R5 R1
    {32'hbf800000, 32'hc0000000, 5'b00100, 4'd5,  4'd5},   // R7
    {32'hc0000000, 32'hbf800000, 5'b10000, 4'd5,  4'd5},   // R7
    {32'h80000001, 32'h00000001, 5'b10000, 4'd3,  4'd2},   // R8 R1
    {32'h7f800000, 32'h7f7fffff, 5'b00100, 4'd6,  4'd4},   // R6
    {32'hff800000, 32'h7f800000, 5'b10000, 4'd7,  4'd6},   // R8
    {32'h7fc00000, 32'h3f800000, 5'b00010, 4'd8,  4'd4},   // R4 R2
    {32'h7f800001, 32'h3f800000, 5'b00011, 4'd10, 4'd4},   // R9 R2
    {32'h3f800000, 32'hffa00000, 5'b00011, 4'd4,  4'd10},  // R9 R2
    {32'h00000001, 32'h00000000, 5'b00100, 4'd2,  4'd0},   // R6 R1
    {32'h80000000, 32'h00000001, 5'b10000, 4'd1,  4'd2},   // R8
    {32'h3f800000, 32'h3f800000, 5'b01000, 4'd4,  4'd4},   // R3
    {32'hffc00000, 32'h7fc00000, 5'b00010, 4'd8,  4'd8},   // R4
    {32'h807fffff, 32'h80000000, 5'b10000, 4'd3,  4'd1}    // R7 R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        is_lt, is_eq, is_gt, is_unord, invalid;
  logic [3:0]  class_a, class_b;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_cmp_class u_fp32_cmp_class (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .is_lt(is_lt), .is_eq(is_eq), .is_gt(is_gt), .is_unord(is_unord),
    .invalid(invalid), .class_a(class_a), .class_b(class_b));

  function automatic string req_of(int i);
    case (i)
      0, 1, 6, 11: req_of = "R6";
      2:           req_of = "R5";
      3, 4, 15:    req_of = "R7";
      5, 7, 12:    req_of = "R8";
      8, 14:       req_of = "R4";
      9, 10:       req_of = "R9";
      default:     req_of = "R3";
    endcase
  endfunction

  task automatic check(string req, logic [12:0] got, logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    op_a = 32'h3f800000;
    op_b = 32'h40000000;
    repeat (2) @(negedge clk);
    // R10 reset state
    check("R10", {is_lt, is_eq, is_gt, is_unord, invalid, class_a, class_b}, '0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_a = VEC[i][76:45];
      op_b = VEC[i][44:13];
      @(negedge clk);
      check(req_of(i), {is_lt, is_eq, is_gt, is_unord, invalid, class_a, class_b}, VEC[i][12:0]);
      // R3 and the class codes of R1 and R2
      checks++;
      if ($countones({is_lt, is_eq, is_gt, is_unord}) != 1) begin
        errors++;
        $display("FAIL R3: got %b expected one flag", {is_lt, is_eq, is_gt, is_unord});
      end
      check((i == 8 || i == 9) ? "R2" : "R1", {5'b0, class_a, class_b}, {5'b0, VEC[i][7:0]});
    end
    // R10 one-edge latency: a new input does not show before the edge
    @(negedge clk);
    op_a = 32'hff800000;
    op_b = 32'h7f800000;
    #1;
    check("R10", {is_lt, is_eq, is_gt, is_unord, invalid, class_a, class_b},
          {5'b10000, 4'd3, 4'd1});
    @(negedge clk);
    check("R10", {is_lt, is_eq, is_gt, is_unord, invalid, class_a, class_b},
          {5'b10000, 4'd7, 4'd6});
    // R10 reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R10", {is_lt, is_eq, is_gt, is_unord, invalid, class_a, class_b}, '0);
    @(negedge clk);
    check("R10", {is_lt, is_eq, is_gt, is_unord, invalid, class_a, class_b}, '0);
    rst_n = 1'b1;
    // R5 negative zero first
    op_a = 32'h80000000;
    op_b = 32'h00000000;
    @(negedge clk);
    check("R5", {is_lt, is_eq, is_gt, is_unord, invalid, class_a, class_b},
          {5'b01000, 4'd1, 4'd0});
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule